// File: doc/BRIEF.md
# Sync Reference Frame Decoder

This block recovers frame timing from a pair of horizontal and vertical sync pulse trains. Output timing logic downstream uses it to align to the start of each reference frame. Two reference ports each bring their own horizontal and vertical sync. A control bit decides whether the active port comes from a register bit or from an external select pin. All four sync inputs and the select pin pass through flip-flop synchronizers before any edge is detected.

No odd/even field input is needed. On every vertical rising edge, the block measures how many clock cycles have passed since the most recent horizontal rising edge. It compares that offset with a programmable window. A pulse inside the window marks an even field or a progressive frame, and it restarts the line count. A pulse outside the window marks an odd field. From this classification the block derives the following outputs:

- a one-cycle frame-start pulse
- a field flag
- the number of lines per frame
- the scan mode (interlaced or progressive)
- a sticky flag, raised when the line counter is reset twice within one frame

That last case is typical of a source whose horizontal and vertical pulses arrive together in both fields.

Top module: `sync_frame_decoder`

## Requirements
- R1: With `sel_by_reg`=1, `sel_reg_b` selects the port (0 = port A, 1 = port B). With `sel_by_reg`=0, the synchronized `sel_pin_b` selects it, with the same encoding. Pulses on the port that is not selected have no effect on any output.
- R2: Every sync input passes through a two-flop synchronizer. A registered result caused by an input rising edge appears after the third rising clock edge that follows the input change.
- R3: A vertical edge is in-window when the number of cycles d since the most recent horizontal edge satisfies d <= `win_max`. A horizontal edge in the same cycle counts as d = 0. Any larger offset, including no horizontal edge since the last clear, is out-of-window.
- R4: `field_odd` becomes 1 after an out-of-window vertical edge and 0 after an in-window one. It does not change otherwise.
- R5: The line counter counts horizontal edges between in-window vertical edges. A horizontal edge coincident with the reset belongs to the new frame. From the second in-window edge after a clear, each in-window edge loads the count into `lines_per_frame`.
- R6: `frame_start` is a one-cycle pulse on an in-window vertical edge. It is withheld for the first two in-window edges after a reset or clear. Out-of-window edges never produce it.
- R7: On each vertical edge after the first one following a clear, the mode is updated from the last two edges. If one was in-window and the other out-of-window, `interlaced`=1. If both were in-window, `progressive`=1. If both were out-of-window, both flags are 0. The two flags are never 1 together.
- R8: `double_reset` is raised on an in-window vertical edge when `lines_per_frame` holds a value and the current line count is smaller than it. The flag stays set until the next reset or clear.
- R9: A change of the effective port selection clears line count, `lines_per_frame`, field, mode, error and frame-start arming, and resets the horizontal age to its maximum.
- R10: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_hsync | input | 1 | Port A horizontal sync |
| a_vsync | input | 1 | Port A vertical sync |
| b_hsync | input | 1 | Port B horizontal sync |
| b_vsync | input | 1 | Port B vertical sync |
| sel_reg_b | input | 1 | Register port choice, 1 = B |
| sel_by_reg | input | 1 | 1 = register bit selects, 0 = pin selects |
| sel_pin_b | input | 1 | External port select pin, 1 = B |
| win_max | input | WIN_W | Largest H-to-V offset, in cycles, counted as in-window |
| frame_start | output | 1 | One-cycle frame-start pulse |
| field_odd | output | 1 | Class of last vertical edge, 1 = odd field |
| lines_per_frame | output | LINE_W | Lines counted between the last two frame resets |
| interlaced | output | 1 | Interlaced mode detected |
| progressive | output | 1 | Progressive mode detected |
| double_reset | output | 1 | Sticky double-reset-per-frame flag |

## Verification
A sync edge driven between two clock edges reaches the second synchronizer stage two rising edges later. The outputs register it on the third rising edge, so every result is due three clocks after its stimulus. The bench counts rising edges and stamps each vertical drive and each `frame_start` rise with that count. It requires a difference of exactly three and a pulse width of one cycle. Status outputs such as field, mode, line count and error are only read at a falling edge at least four clocks after the last pulse of a scenario, when no further update is pending.

// File: rtl/srfd_pkg.sv
package srfd_pkg;
   // Classification of one vertical edge relative to the offset window
   typedef enum logic {
      VCLS_OUT = 1'b0,
      VCLS_IN  = 1'b1
   } vcls_e;

   localparam int SRFD_MIN_SYNC = 2;
   localparam int SRFD_MIN_W    = 2;
endpackage

// File: rtl/srfd_sync.sv
module srfd_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < srfd_pkg::SRFD_MIN_SYNC) begin : g_bad
      $error("srfd_sync: STAGES below minimum");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stg[i-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/srfd_offset.sv
module srfd_offset #(
   parameter int AGE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hs_edge,
   input  logic [AGE_W-1:0] win,
   output logic             in_win
);
   if (AGE_W < srfd_pkg::SRFD_MIN_W) begin : g_bad
      $error("srfd_offset: AGE_W too small");
   end

   localparam logic [AGE_W-1:0] AGE_MAX = '1;
   localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

   logic [AGE_W-1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age <= AGE_MAX;
      else if (clr)            age <= AGE_MAX;
      else if (hs_edge)        age <= AGE_ONE;
      else if (age != AGE_MAX) age <= age + AGE_ONE;
   end

   assign in_win = hs_edge | (age <= win);
endmodule

// File: rtl/srfd_frame.sv
module srfd_frame #(
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              hs_edge,
   input  logic              vs_edge,
   input  logic              in_win,
   output logic              frame_start,
   output logic              field_odd,
   output logic [LINE_W-1:0] lines,
   output logic              interlaced,
   output logic              progressive,
   output logic              dbl_err
);
   import srfd_pkg::*;

   if (LINE_W < SRFD_MIN_W) begin : g_bad
      $error("srfd_frame: LINE_W too small");
   end

   localparam logic [LINE_W-1:0] LINE_MAX = '1;
   localparam logic [1:0]        ARMED    = 2'd2;

   logic [LINE_W-1:0] line_cnt;
   logic [1:0]        arm;
   logic              last_vld;
   vcls_e             last_cls;
   vcls_e             cur_cls;
   logic              v_in;

   assign cur_cls = in_win ? VCLS_IN : VCLS_OUT;
   assign v_in    = vs_edge & in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         line_cnt    <= '0;
         lines       <= '0;
         arm         <= '0;
         last_vld    <= 1'b0;
         last_cls    <= VCLS_OUT;
         frame_start <= 1'b0;
         field_odd   <= 1'b0;
         interlaced  <= 1'b0;
         progressive <= 1'b0;
         dbl_err     <= 1'b0;
      end else begin
         frame_start <= 1'b0;
         if (v_in) begin
            line_cnt <= {{(LINE_W-1){1'b0}}, hs_edge};
            if (arm != 2'd0) lines <= line_cnt;
            if (arm == ARMED) begin
               frame_start <= 1'b1;
               if (line_cnt < lines) dbl_err <= 1'b1;
            end else begin
               arm <= arm + 2'd1;
            end
         end else if (hs_edge && line_cnt != LINE_MAX) begin
            line_cnt <= line_cnt + 1'b1;
         end
         if (vs_edge) begin
            field_odd <= (cur_cls == VCLS_OUT);
            last_vld  <= 1'b1;
            last_cls  <= cur_cls;
            if (last_vld) begin
               interlaced  <= (last_cls != cur_cls);
               progressive <= (last_cls == VCLS_IN) && (cur_cls == VCLS_IN);
            end
         end
      end
   end
endmodule

// File: rtl/sync_frame_decoder.sv
module sync_frame_decoder #(
   parameter int WIN_W       = 12,
   parameter int LINE_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_hsync,
   input  logic              a_vsync,
   input  logic              b_hsync,
   input  logic              b_vsync,
   input  logic              sel_reg_b,
   input  logic              sel_by_reg,
   input  logic              sel_pin_b,
   input  logic [WIN_W-1:0]  win_max,
   output logic              frame_start,
   output logic              field_odd,
   output logic [LINE_W-1:0] lines_per_frame,
   output logic              interlaced,
   output logic              progressive,
   output logic              double_reset
);
   localparam int IDX_AH  = 0;
   localparam int IDX_AV  = 1;
   localparam int IDX_BH  = 2;
   localparam int IDX_BV  = 3;
   localparam int IDX_PIN = 4;
   localparam int NSYNC   = IDX_PIN + 1;

   logic [NSYNC-1:0] raw, syn;
   logic sel_eff, sel_q, clr;
   logic hs_s, vs_s, hs_d, vs_d;
   logic hs_edge, vs_edge, win_hit;

   assign raw = {sel_pin_b, b_vsync, b_hsync, a_vsync, a_hsync};

   srfd_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   assign sel_eff = sel_by_reg ? sel_reg_b : syn[IDX_PIN];
   assign hs_s    = sel_eff ? syn[IDX_BH] : syn[IDX_AH];
   assign vs_s    = sel_eff ? syn[IDX_BV] : syn[IDX_AV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         hs_d  <= 1'b0;
         vs_d  <= 1'b0;
      end else begin
         sel_q <= sel_eff;
         hs_d  <= hs_s;
         vs_d  <= vs_s;
      end
   end

   assign clr     = sel_eff != sel_q;
   assign hs_edge = hs_s & ~hs_d & ~clr;
   assign vs_edge = vs_s & ~vs_d & ~clr;

   srfd_offset #(.AGE_W(WIN_W)) u_offset (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .hs_edge (hs_edge),
      .win     (win_max),
      .in_win  (win_hit)
   );

   srfd_frame #(.LINE_W(LINE_W)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .hs_edge     (hs_edge),
      .vs_edge     (vs_edge),
      .in_win      (win_hit),
      .frame_start (frame_start),
      .field_odd   (field_odd),
      .lines       (lines_per_frame),
      .interlaced  (interlaced),
      .progressive (progressive),
      .dbl_err     (double_reset)
   );
endmodule

// File: rtl/sync_frame_decoder_chk.sv
module sync_frame_decoder_chk #(
   parameter int LINE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              vs_edge,
   input logic              win_hit,
   input logic              frame_start,
   input logic              field_odd,
   input logic [LINE_W-1:0] lines_per_frame,
   input logic              interlaced,
   input logic              progressive,
   input logic              double_reset
);
   assert_fs_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   assert_fs_needs_inwin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> $past(vs_edge && win_hit));

   assert_mode_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(interlaced && progressive));

   assert_field_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!vs_edge && !clr) |=> $stable(field_odd));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (double_reset && !clr) |=> double_reset);

   assert_port_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (lines_per_frame == '0 && !interlaced && !progressive
               && !double_reset && !frame_start && !field_odd));
endmodule

bind sync_frame_decoder sync_frame_decoder_chk #(.LINE_W(LINE_W)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .clr             (clr),
   .vs_edge         (vs_edge),
   .win_hit         (win_hit),
   .frame_start     (frame_start),
   .field_odd       (field_odd),
   .lines_per_frame (lines_per_frame),
   .interlaced      (interlaced),
   .progressive     (progressive),
   .double_reset    (double_reset)
);

// File: tb/sync_frame_decoder_tb_top.sv
module sync_frame_decoder_tb_top;
   localparam int WIN_W  = 12;
   localparam int LINE_W = 12;
   localparam int LLEN   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_hsync = 0, a_vsync = 0, b_hsync = 0, b_vsync = 0;
   logic sel_reg_b = 0, sel_by_reg = 1, sel_pin_b = 1;
   logic [WIN_W-1:0] win_max = WIN_W'(3);
   logic frame_start, field_odd, interlaced, progressive, double_reset;
   logic [LINE_W-1:0] lines_per_frame;

   int checks = 0, failures = 0;
   int cyc_cnt = 0;
   int v_drive_cyc = 0, fs_rise_cyc = -100;
   int fs_cnt = 0, fs_run = 0, fs_maxw = 0;
   logic fs_prev = 1'b0;

   always #2.5 clk = ~clk;

   sync_frame_decoder #(.WIN_W(WIN_W), .LINE_W(LINE_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_hsync(a_hsync), .a_vsync(a_vsync), .b_hsync(b_hsync), .b_vsync(b_vsync),
      .sel_reg_b(sel_reg_b), .sel_by_reg(sel_by_reg), .sel_pin_b(sel_pin_b),
      .win_max(win_max),
      .frame_start(frame_start), .field_odd(field_odd),
      .lines_per_frame(lines_per_frame), .interlaced(interlaced),
      .progressive(progressive), .double_reset(double_reset)
   );

   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_start) begin
            fs_cnt = fs_cnt + 1;
            if (!fs_prev) fs_rise_cyc = cyc_cnt;
            fs_run = fs_run + 1;
            if (fs_run > fs_maxw) fs_maxw = fs_run;
         end else begin
            fs_run = 0;
         end
         fs_prev = frame_start;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   task automatic drive(input int p, input bit h, input bit v);
      if (p == 0) begin a_hsync = h; a_vsync = v; end
      else        begin b_hsync = h; b_vsync = v; end
   endtask

   // one line: H pulse at step 0, V pulse at step vpos (vpos < 0 means none)
   task automatic send_line(input int p, input int vpos);
      for (int i = 0; i < LLEN; i++) begin
         @(negedge clk);
         drive(p, i == 0, i == vpos);
         if (i == vpos) v_drive_cyc = cyc_cnt;
      end
   endtask

   task automatic send_field(input int p, input int nlines, input int vpos);
      for (int l = 0; l < nlines; l++) send_line(p, (l == 0) ? vpos : -1);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state;
      chk_eq("R10 frame_start", int'(frame_start), 0);
      chk_eq("R10 lines", int'(lines_per_frame), 0);
      chk_eq("R10 flags", int'({field_odd, interlaced, progressive, double_reset}), 0);
   endtask

   task automatic t_progressive_a;
      int f0;
      f0 = fs_cnt;
      for (int f = 0; f < 4; f++) send_field(0, 4, 2);
      idle(4);
      chk_eq("R6 withheld first two, pulses", fs_cnt - f0, 2);
      chk_eq("R2 frame_start latency", fs_rise_cyc - v_drive_cyc, 3);
      chk_eq("R6 pulse width", fs_maxw, 1);
      chk_eq("R5 lines_per_frame", int'(lines_per_frame), 4);
      chk_eq("R7 progressive", int'(progressive), 1);
      chk_eq("R7 not interlaced", int'(interlaced), 0);
      chk_eq("R4 field even", int'(field_odd), 0);
   endtask

   task automatic t_other_port_ignored;
      int f0;
      f0 = fs_cnt;
      for (int f = 0; f < 3; f++) send_field(1, 2, 5);
      idle(4);
      chk_eq("R1 port B ignored fs", fs_cnt - f0, 0);
      chk_eq("R1 port B ignored lines", int'(lines_per_frame), 4);
      chk_eq("R1 port B ignored field", int'(field_odd), 0);
   endtask

   task automatic t_switch_reg_b;
      @(negedge clk);
      sel_reg_b = 1'b1;
      idle(4);
      chk_eq("R9 clear lines", int'(lines_per_frame), 0);
      chk_eq("R9 clear mode", int'({interlaced, progressive}), 0);
   endtask

   task automatic t_interlaced_b;
      int f0;
      f0 = fs_cnt;
      for (int f = 0; f < 4; f++) begin
         send_field(1, 3, 1);
         send_field(1, 3, 6);
      end
      idle(4);
      chk_eq("R6 out-of-window no pulse", fs_cnt - f0, 2);
      chk_eq("R5 interlaced frame lines", int'(lines_per_frame), 6);
      chk_eq("R7 interlaced", int'(interlaced), 1);
      chk_eq("R7 not progressive", int'(progressive), 0);
      chk_eq("R4 odd field", int'(field_odd), 1);
      chk_eq("R8 compliant no error", int'(double_reset), 0);
   endtask

   task automatic t_window_edge;
      send_line(1, 3);
      idle(4);
      chk_eq("R3 offset equal to window in", int'(field_odd), 0);
      send_line(1, 4);
      idle(4);
      chk_eq("R3 offset above window out", int'(field_odd), 1);
   endtask

   task automatic t_pin_select;
      int f0;
      @(negedge clk);
      sel_pin_b = 1'b0;
      sel_by_reg = 1'b0;
      idle(6);
      chk_eq("R1 pin select clears lines", int'(lines_per_frame), 0);
      f0 = fs_cnt;
      for (int f = 0; f < 3; f++) send_field(0, 4, 2);
      idle(4);
      chk_eq("R1 pin picks A", fs_cnt - f0, 1);
      @(negedge clk);
      sel_pin_b = 1'b1;
      idle(6);
      chk_eq("R9 pin change clears", int'(lines_per_frame), 0);
   endtask

   task automatic t_double_reset_b;
      for (int k = 0; k < 2; k++) begin
         send_field(1, 3, 0);
         send_field(1, 4, 0);
      end
      send_line(1, 0);
      idle(4);
      chk_eq("R8 double reset flagged", int'(double_reset), 1);
      chk_eq("R7 co-timed looks progressive", int'(progressive), 1);
      send_field(1, 4, 0);
      idle(4);
      chk_eq("R8 flag sticky", int'(double_reset), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      idle(4);
      t_progressive_a();
      t_other_port_ignored();
      t_switch_reg_b();
      t_interlaced_b();
      t_window_edge();
      t_pin_select();
      t_double_reset_b();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule